// File: doc/BRIEF.md
# Multi-level vectored interrupt arbiter

The arbiter keeps a two-dimensional set of interrupt requests: a number of priority levels, each with a row of request slots. A slot is named by a flat index. Its level is the index divided by the slot count per level, and its bit within that level is the index modulo that count. The processor supplies its current priority. Only levels strictly above that priority can interrupt it, and the arbiter raises a pending flag whenever any of those levels holds a request.

When the processor acknowledges, the arbiter picks one winner. It takes the highest eligible level and, within that level, the lowest-numbered set bit. It clears that request and returns the vector for the slot one cycle later, together with a single-cycle valid pulse.

Each slot's vector comes from one of two places. It is either a stored table entry, or, when the slot is marked as device-sourced, a value the device drives during the acknowledge cycle. The winning slot index is presented combinationally so that the device can respond. On reset the table holds zero everywhere except one reserved software-interrupt slot on every level from 1 upward, which is preloaded with a shared vector.

Top module: `irq_vec_arbiter`

## Requirements
- R1: After reset the pending flag is low, the vector valid output is low, the vector output is zero and no request is held.
- R2: A high bit on the set lines records the request for that flat index at the next clock edge, and a high bit on the clear lines removes it. A set and a clear of the same index in the same cycle leave the request recorded. A set in the same cycle as that slot's grant also leaves it recorded.
- R3: The pending flag is high exactly when some level strictly greater than the current priority holds a request. Flat index i belongs to level i/32 and bit i%32 with the default sizes, so level 0 never interrupts.
- R4: On acknowledge the winner is found in the highest eligible level, and within that level it is the lowest-numbered set bit. Its flat index is shown on the acknowledge slot output during the acknowledge cycle.
- R5: The winning request is cleared at the clock edge that samples the acknowledge.
- R6: The vector and its valid flag are registered. Valid is high for the one cycle after an acknowledge cycle and low otherwise.
- R7: The table write port stores a vector and a device-source flag for the addressed slot. A slot without the device flag returns its stored vector.
- R8: A slot with the device-source flag returns the value on the device vector input, sampled in the acknowledge cycle.
- R9: An acknowledge with no eligible request returns vector zero with valid high and changes no request.
- R10: After reset, slot 31 of each level 1 to 7 (default sizes) returns the shared software-interrupt vector 0x00A0.
- R11: The pending flag follows a change of the current priority in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_set_i | input | 256 | Per-slot request set lines, flat index |
| req_clr_i | input | 256 | Per-slot request clear lines, flat index |
| cur_prio_i | input | 3 | Current processor priority |
| ack_i | input | 1 | Acknowledge strobe |
| dev_vec_i | input | 16 | Device-supplied vector, sampled in the acknowledge cycle |
| tbl_we_i | input | 1 | Vector table write enable |
| tbl_addr_i | input | 8 | Vector table slot address |
| tbl_vec_i | input | 16 | Vector to store |
| tbl_dev_i | input | 1 | Device-source flag to store |
| irq_pending_o | output | 1 | An eligible request exists |
| ack_slot_o | output | 8 | Flat index of the current winner, zero when none |
| vec_o | output | 16 | Returned vector |
| vec_valid_o | output | 1 | Vector valid pulse |

## Verification
Damage to the request register shows up in the same cycle as a wrong pending flag. A bit that is not cleared on grant shows up when a later acknowledge returns the same vector twice. A mistake in the scan order appears at the acknowledge slot output before the acknowledge edge is even taken, and as a wrong vector one cycle later. A corrupted table entry or device flag is visible only at the first acknowledge of that slot, so the directed tests acknowledge every slot they configure.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LEVELS_DEF    = 8;
  localparam int unsigned SLOTS_DEF     = 32;
  localparam int unsigned VEC_W_DEF     = 16;
  localparam int unsigned SOFT_SLOT_DEF = 31;
  localparam logic [15:0] SOFT_VEC_DEF  = 16'h00A0;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int unsigned N     = 256,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     clr_i,
  input  logic             grant_en_i,
  input  logic [IDX_W-1:0] grant_idx_i,
  output logic [N-1:0]     req_o
);
  logic [N-1:0] req_q, req_d, clr_eff;

  always_comb begin
    clr_eff = clr_i;
    if (grant_en_i) clr_eff[grant_idx_i] = 1'b1;
    // set dominates any clear, including the grant clear
    req_d = (req_q & ~clr_eff) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign req_o = req_q;

  // R2
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));

  // R5
  grant_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_en_i && !set_i[grant_idx_i]) |=> !req_q[$past(grant_idx_i)]);
endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
  parameter int unsigned LEVELS = 8,
  parameter int unsigned SLOTS  = 32,
  localparam int unsigned N      = LEVELS * SLOTS,
  localparam int unsigned PRIO_W = $clog2(LEVELS),
  localparam int unsigned BIT_W  = $clog2(SLOTS),
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_i,
  input  logic [PRIO_W-1:0] prio_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  win_idx_o
);
  logic [LEVELS-1:0] lvl_elig;
  logic [BIT_W-1:0]  lvl_first [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    logic [SLOTS-1:0] row;
    assign row = req_i[l*SLOTS +: SLOTS];
    assign lvl_elig[l] = (|row) && (PRIO_W'(l) > prio_i);

    always_comb begin
      lvl_first[l] = '0;
      for (int b = SLOTS - 1; b >= 0; b--)
        if (row[b]) lvl_first[l] = BIT_W'(b);
    end
  end

  always_comb begin
    win_idx_o = '0;
    for (int l = 0; l < LEVELS; l++)
      if (lvl_elig[l]) win_idx_o = {PRIO_W'(l), lvl_first[l]};
  end

  assign found_o = |lvl_elig;

  // R4
  win_is_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> req_i[win_idx_o]);

  // R3
  win_above_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (win_idx_o[IDX_W-1 -: PRIO_W] > prio_i));
endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
  parameter int unsigned    LEVELS    = 8,
  parameter int unsigned    SLOTS     = 32,
  parameter int unsigned    VEC_W     = 16,
  parameter int unsigned    SOFT_SLOT = 31,
  parameter logic [VEC_W-1:0] SOFT_VEC = 16'h00A0,
  localparam int unsigned N     = LEVELS * SLOTS,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [VEC_W-1:0] wvec_i,
  input  logic             wdev_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [VEC_W-1:0] rvec_o,
  output logic             rdev_o
);
  logic [VEC_W-1:0] vec_q [N];
  logic [N-1:0]     dev_q;

  function automatic logic [VEC_W-1:0] rst_vec(int k);
    if ((k / SLOTS) != 0 && (k % SLOTS) == SOFT_SLOT) return SOFT_VEC;
    return '0;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) vec_q[k] <= rst_vec(k);
      dev_q <= '0;
    end else if (we_i) begin
      vec_q[waddr_i] <= wvec_i;
      dev_q[waddr_i] <= wdev_i;
    end
  end

  assign rvec_o = vec_q[raddr_i];
  assign rdev_o = dev_q[raddr_i];

  // R7
  tbl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vec_q[$past(waddr_i)] == $past(wvec_i)) && (dev_q[$past(waddr_i)] == $past(wdev_i)));
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned      NUM_LEVELS = LEVELS_DEF,
  parameter int unsigned      SLOTS      = SLOTS_DEF,
  parameter int unsigned      VEC_W      = VEC_W_DEF,
  parameter int unsigned      SOFT_SLOT  = SOFT_SLOT_DEF,
  parameter logic [VEC_W-1:0] SOFT_VEC   = SOFT_VEC_DEF,
  localparam int unsigned N      = NUM_LEVELS * SLOTS,
  localparam int unsigned PRIO_W = $clog2(NUM_LEVELS),
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      req_set_i,
  input  logic [N-1:0]      req_clr_i,
  input  logic [PRIO_W-1:0] cur_prio_i,
  input  logic              ack_i,
  input  logic [VEC_W-1:0]  dev_vec_i,
  input  logic              tbl_we_i,
  input  logic [IDX_W-1:0]  tbl_addr_i,
  input  logic [VEC_W-1:0]  tbl_vec_i,
  input  logic              tbl_dev_i,
  output logic              irq_pending_o,
  output logic [IDX_W-1:0]  ack_slot_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  logic [N-1:0]     req;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  logic [VEC_W-1:0] tbl_vec, vec_d, vec_q;
  logic             tbl_dev, valid_q;

  irq_req_bank #(.N(N)) u_bank (
    .clk_i, .rst_ni,
    .set_i      (req_set_i),
    .clr_i      (req_clr_i),
    .grant_en_i (ack_i && found),
    .grant_idx_i(win_idx),
    .req_o      (req)
  );

  irq_level_scan #(.LEVELS(NUM_LEVELS), .SLOTS(SLOTS)) u_scan (
    .clk_i, .rst_ni,
    .req_i    (req),
    .prio_i   (cur_prio_i),
    .found_o  (found),
    .win_idx_o(win_idx)
  );

  irq_vec_table #(
    .LEVELS(NUM_LEVELS), .SLOTS(SLOTS), .VEC_W(VEC_W),
    .SOFT_SLOT(SOFT_SLOT), .SOFT_VEC(SOFT_VEC)
  ) u_tbl (
    .clk_i, .rst_ni,
    .we_i   (tbl_we_i),
    .waddr_i(tbl_addr_i),
    .wvec_i (tbl_vec_i),
    .wdev_i (tbl_dev_i),
    .raddr_i(win_idx),
    .rvec_o (tbl_vec),
    .rdev_o (tbl_dev)
  );

  always_comb begin
    if (!found)      vec_d = '0;
    else if (tbl_dev) vec_d = dev_vec_i;
    else              vec_d = tbl_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ack_i;
      if (ack_i) vec_q <= vec_d;
    end
  end

  assign irq_pending_o = found;
  assign ack_slot_o    = win_idx;
  assign vec_o         = vec_q;
  assign vec_valid_o   = valid_q;

  // R6
  valid_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i));

  // R9
  empty_ack_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_pending_o) |=> (vec_o == '0));

  // R3
  top_prio_masks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_prio_i == '1) |-> !irq_pending_o);
endmodule

// File: tb/sim_irq_vec_arbiter.sv
module sim_irq_vec_arbiter;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] set_l, clr_l;
  logic [2:0]   prio;
  logic         ack;
  logic [15:0]  dev_vec;
  logic         we;
  logic [7:0]   addr;
  logic [15:0]  wvec;
  logic         wdev;
  logic         pending;
  logic [7:0]   slot;
  logic [15:0]  vec;
  logic         valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  irq_vec_arbiter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_set_i(set_l), .req_clr_i(clr_l),
    .cur_prio_i(prio), .ack_i(ack), .dev_vec_i(dev_vec),
    .tbl_we_i(we), .tbl_addr_i(addr), .tbl_vec_i(wvec), .tbl_dev_i(wdev),
    .irq_pending_o(pending), .ack_slot_o(slot),
    .vec_o(vec), .vec_valid_o(valid)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(bit do_set, bit do_clr, int idx);
    @(negedge clk);
    if (do_set) set_l[idx] = 1'b1;
    if (do_clr) clr_l[idx] = 1'b1;
    @(negedge clk);
    set_l = '0;
    clr_l = '0;
  endtask

  task automatic load(int idx, logic [15:0] v, bit d);
    @(negedge clk);
    we = 1'b1; addr = 8'(idx); wvec = v; wdev = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic do_ack(string req, logic [15:0] dv, int exp_slot, logic [15:0] exp_vec);
    @(negedge clk);
    ack = 1'b1; dev_vec = dv;
    #1;
    chk({req, " slot"}, 32'(slot), 32'(exp_slot));
    @(negedge clk);
    ack = 1'b0; dev_vec = '0;
    chk({req, " valid"}, 32'(valid), 1);
    chk({req, " vec"}, 32'(vec), 32'(exp_vec));
    @(negedge clk);
    chk("R6 valid drops", 32'(valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 pending", 32'(pending), 0);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 vec", 32'(vec), 0);
  endtask

  task automatic t_pending;
    pulse(1, 0, 101);           // level 3 bit 5
    prio = 3'd2; #1;
    chk("R3 above prio", 32'(pending), 1);
    prio = 3'd3; #1;
    chk("R11 equal prio masks", 32'(pending), 0);
    prio = 3'd7; #1;
    chk("R3 top prio masks", 32'(pending), 0);
    prio = 3'd0;
    pulse(0, 1, 101);
    chk("R2 clear", 32'(pending), 0);
    pulse(1, 0, 5);             // level 0
    chk("R3 level 0 never", 32'(pending), 0);
    pulse(0, 1, 5);
  endtask

  task automatic t_set_clr;
    pulse(1, 1, 40);
    chk("R2 set wins", 32'(pending), 1);
    pulse(0, 1, 40);
    chk("R2 clear after", 32'(pending), 0);
  endtask

  task automatic t_table;
    load(101, 16'h1234, 1'b0);
    pulse(1, 0, 101);
    prio = 3'd2;
    do_ack("R7 table vec", 16'hFFFF, 101, 16'h1234);
    chk("R5 cleared", 32'(pending), 0);
    prio = 3'd0;
  endtask

  task automatic t_order;
    load(103, 16'h0107, 1'b0);
    load(100, 16'h0104, 1'b0);
    load(180, 16'h0520, 1'b0);
    pulse(1, 0, 103);
    pulse(1, 0, 100);
    pulse(1, 0, 180);
    do_ack("R4 high level", 16'h0, 180, 16'h0520);
    do_ack("R4 low bit", 16'h0, 100, 16'h0104);
    do_ack("R4 last", 16'h0, 103, 16'h0107);
    chk("R5 all cleared", 32'(pending), 0);
  endtask

  task automatic t_dev;
    load(65, 16'h0000, 1'b1);
    pulse(1, 0, 65);
    do_ack("R8 device vec", 16'h0ABC, 65, 16'h0ABC);
  endtask

  task automatic t_none;
    pulse(1, 0, 200);           // level 6
    prio = 3'd7; #1;
    chk("R9 masked", 32'(pending), 0);
    do_ack("R9 empty", 16'h5555, 0, 16'h0000);
    prio = 3'd0; #1;
    chk("R9 request kept", 32'(pending), 1);
    pulse(0, 1, 200);
  endtask

  task automatic t_soft;
    pulse(1, 0, 159);           // level 4 slot 31
    do_ack("R10 soft level 4", 16'h0, 159, 16'h00A0);
    pulse(1, 0, 255);           // level 7 slot 31
    do_ack("R10 soft level 7", 16'h0, 255, 16'h00A0);
  endtask

  task automatic t_grant_set;
    load(130, 16'h0402, 1'b0);
    pulse(1, 0, 130);
    @(negedge clk);
    ack = 1'b1; set_l[130] = 1'b1;
    @(negedge clk);
    ack = 1'b0; set_l = '0;
    chk("R2 grant vec", 32'(vec), 32'h0402);
    chk("R2 set beats grant", 32'(pending), 1);
    pulse(0, 1, 130);
    chk("R2 final clear", 32'(pending), 0);
  endtask

  initial begin
    rst_n = 1'b0; set_l = '0; clr_l = '0; prio = '0; ack = 1'b0;
    dev_vec = '0; we = 1'b0; addr = '0; wvec = '0; wdev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_set_clr();
    t_table();
    t_order();
    t_dev();
    t_none();
    t_soft();
    t_grant_set();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule